// File: doc/BRIEF.md
# DMA Channel Bus-Request Sequencer

This block is the control core of one 32-bit DMA channel. A requester, typically an interrupt controller that forwards a peripheral event, raises a level request. The channel asks the processor core for bus ownership on one of two request lines. One line is a snoop-style request, under which the core keeps its data bus. The other is a general request, under which the core hands the bus over fully. Once the matching grant returns, the channel runs bus cycles of a configured unit size and decrements a byte counter after each one.

The acknowledge back to the requester depends on the transfer type. In single mode it pulses after every unit, so each unit needs a fresh request. In continuous mode it pulses only when the counter reaches zero, so one request drives back-to-back units. When no request remains pending, the channel drops its bus request.

In general-request mode the core may ask for the bus back. If release is enabled, the channel gives the bus up at the next unit boundary and then requests it again. Address generation and the memory bus are outside the block: a bus-cycle active / cycle-done handshake stands in for them.

Top module: `dma_bus_seq`

## Requirements
- R1: The bus request goes out on `snoop_req` when the mode captured at the start of a run is snoop (`cfg_snoop`=1), and on `gen_req` otherwise. The two lines are never high together, and one of them is high whenever `cyc_act` is high.
- R2: `cyc_act` rises only in the cycle after the grant that matches the active request line was seen high. A grant on the other line starts nothing.
- R3: In single mode (`cfg_cont`=0) `ack` is a one-cycle pulse after each completed unit. A request that stays high after the pulse starts no further unit; only a new rising edge of `xfer_req` does.
- R4: In continuous mode (`cfg_cont`=1) one rising edge of `xfer_req` drives units back to back, with `cyc_act` kept high. `ack` pulses once, and only when the counter reaches zero.
- R5: The unit size is encoded by `cfg_unit`: 00 means 1 byte, 01 means 2 bytes, 10 and 11 mean 4 bytes. Each completed unit decrements `byte_cnt` by the unit size. A unit larger than the remaining count is clipped to that count, and the clipped size is shown on `cyc_bytes`.
- R6: After the `ack` pulse, the bus request line is low in the following cycle and stays low until a new request is pending.
- R7: In general-request mode with `cfg_rel_en`=1, a high `core_rel_req` releases the bus only at a unit boundary; a cycle in progress is never cut short. When work remains, the channel raises its request again.
- R8: `core_rel_req` has no effect in snoop mode or when `cfg_rel_en`=0. The request line stays high through the whole continuous run.
- R9: `start_set` sets `busy` only if `byte_cnt` is nonzero. Reaching zero clears `busy` and sets a sticky `done`, which is cleared only by `done_clr`.
- R10: After reset all outputs are low and `byte_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_snoop | input | 1 | 1 selects snoop-style request, 0 general request |
| cfg_rel_en | input | 1 | Allow release on core demand (general mode only) |
| cfg_cont | input | 1 | 1 continuous transfer, 0 single transfer |
| cfg_unit | input | 2 | Unit size code |
| cnt_load | input | 1 | Load byte counter from cnt_val |
| cnt_val | input | 32 | Byte count to load |
| start_set | input | 1 | Enable the channel |
| done_clr | input | 1 | Clear the sticky done flag |
| xfer_req | input | 1 | Transfer request from the requester |
| snoop_req | output | 1 | Snoop-style bus request |
| gen_req | output | 1 | General bus request |
| snoop_gnt | input | 1 | Grant for snoop_req |
| gen_gnt | input | 1 | Grant for gen_req |
| core_rel_req | input | 1 | Core asks for the bus back |
| cyc_act | output | 1 | Bus cycle in progress |
| cyc_bytes | output | 3 | Bytes moved by the current cycle |
| cyc_done | input | 1 | Bus cycle completed |
| ack | output | 1 | One-cycle acknowledge to the requester |
| busy | output | 1 | Channel enabled |
| done | output | 1 | Sticky run-complete flag |
| byte_cnt | output | 32 | Remaining byte count |

## Verification
The bench grants on the wrong request line and expects no bus cycle; a design that ignored which line it asked on would start early. It holds the request high after a single-mode acknowledge, which catches a design that re-triggers on the level instead of a fresh edge. It runs a continuous transfer whose count is not a multiple of the unit size, so a design without clipping would underflow the counter or acknowledge at the wrong time. It raises a core release request in the middle of a bus cycle, and with snoop mode or release disabled, to expose a design that aborts mid-cycle or honours the release where it must not.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int UNIT_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_REQ_BUS  = 3'd1,
    ST_TRANSFER = 3'd2,
    ST_ACK      = 3'd3,
    ST_RELEASE  = 3'd4
  } seq_state_t;

  function automatic logic [UNIT_W-1:0] unit_bytes(input logic [1:0] code);
    case (code)
      2'b00:   unit_bytes = UNIT_W'(1);
      2'b01:   unit_bytes = UNIT_W'(2);
      default: unit_bytes = UNIT_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/dma_byte_ctr.sv
module dma_byte_ctr #(
  parameter int CNT_W  = 32,
  parameter int UNIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              dec,
  input  logic [UNIT_W-1:0] unit_b,
  output logic [CNT_W-1:0]  cnt,
  output logic [UNIT_W-1:0] clip_nx,
  output logic              nx_zero
);

  logic [CNT_W-1:0]  cnt_nx;
  logic [UNIT_W-1:0] clip_now;

  function automatic logic [UNIT_W-1:0] clip_of(input logic [CNT_W-1:0] c,
                                                input logic [UNIT_W-1:0] u);
    if (c < CNT_W'(u)) clip_of = c[UNIT_W-1:0];
    else               clip_of = u;
  endfunction

  always_comb begin
    clip_now = clip_of(cnt, unit_b);
    if (load)     cnt_nx = load_val;
    else if (dec) cnt_nx = cnt - CNT_W'(clip_now);
    else          cnt_nx = cnt;
    clip_nx = clip_of(cnt_nx, unit_b);
    nx_zero = (cnt_nx == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nx;
  end

  // R5
  cnt_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/dma_req_track.sv
module dma_req_track (
  input  logic clk,
  input  logic rst,
  input  logic xfer_req,
  input  logic start_set,
  input  logic cnt_nonzero,
  input  logic pend_clr,
  input  logic zero_hit,
  input  logic done_clr,
  output logic busy,
  output logic done,
  output logic pend
);

  logic req_q;
  logic req_rise;

  assign req_rise = xfer_req && !req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      pend  <= 1'b0;
    end else begin
      req_q <= xfer_req;
      if (zero_hit)                      busy <= 1'b0;
      else if (start_set && cnt_nonzero) busy <= 1'b1;
      if (zero_hit)      done <= 1'b1;
      else if (done_clr) done <= 1'b0;
      if (!busy || pend_clr) pend <= 1'b0;
      if (busy && req_rise)  pend <= 1'b1;
    end
  end

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !done_clr) |=> done);

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int UNIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_snoop,
  input  logic              cfg_rel_en,
  input  logic              cfg_cont,
  input  logic [1:0]        cfg_unit,
  input  logic              busy,
  input  logic              pend,
  input  logic              snoop_gnt,
  input  logic              gen_gnt,
  input  logic              core_rel_req,
  input  logic              cyc_done,
  input  logic              nx_zero,
  input  logic [UNIT_W-1:0] clip_nx,
  output logic [UNIT_W-1:0] unit_q,
  output logic              dec,
  output logic              pend_clr,
  output logic              snoop_req,
  output logic              gen_req,
  output logic              cyc_act,
  output logic [UNIT_W-1:0] cyc_bytes,
  output logic              ack
);

  seq_state_t st, nx;
  logic mode_q, rel_q, cont_q;
  logic gnt_sel, rel_ok, bus_on, nx_mode;

  assign gnt_sel  = mode_q ? snoop_gnt : gen_gnt;
  assign rel_ok   = !mode_q && rel_q && core_rel_req;
  assign dec      = (st == ST_TRANSFER) && cyc_done;
  assign pend_clr = (nx == ST_ACK);
  assign bus_on   = (nx == ST_REQ_BUS) || (nx == ST_TRANSFER) || (nx == ST_ACK);
  assign nx_mode  = (st == ST_IDLE) ? cfg_snoop : mode_q;

  always_comb begin
    nx = st;
    case (st)
      ST_IDLE:     if (busy && pend) nx = ST_REQ_BUS;
      ST_REQ_BUS:  if (gnt_sel) nx = ST_TRANSFER;
      ST_TRANSFER: if (cyc_done) begin
                     if (!cont_q || nx_zero) nx = ST_ACK;
                     else if (rel_ok)        nx = ST_RELEASE;
                     else                    nx = ST_TRANSFER;
                   end
      ST_ACK:      nx = ST_RELEASE;
      ST_RELEASE:  nx = ST_IDLE;
      default:     nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mode_q    <= 1'b0;
      rel_q     <= 1'b0;
      cont_q    <= 1'b0;
      unit_q    <= UNIT_W'(1);
      snoop_req <= 1'b0;
      gen_req   <= 1'b0;
      cyc_act   <= 1'b0;
      cyc_bytes <= '0;
      ack       <= 1'b0;
    end else begin
      st <= nx;
      if (st == ST_IDLE) begin
        mode_q <= cfg_snoop;
        rel_q  <= cfg_rel_en;
        cont_q <= cfg_cont;
        unit_q <= unit_bytes(cfg_unit);
      end
      snoop_req <= bus_on && nx_mode;
      gen_req   <= bus_on && !nx_mode;
      cyc_act   <= (nx == ST_TRANSFER);
      cyc_bytes <= (nx == ST_TRANSFER) ? clip_nx : '0;
      ack       <= (nx == ST_ACK);
    end
  end

  // R1
  cyc_has_bus_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_act |-> (snoop_req ^ gen_req));

  // R2
  cyc_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc_act) |-> $past(gnt_sel));

  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R7
  rel_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_act && !cyc_done) |=> cyc_act);

  // R8
  snoop_keeps_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (snoop_req && cyc_act && cyc_done && cont_q && !nx_zero) |=> cyc_act);

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_snoop,
  input  logic             cfg_rel_en,
  input  logic             cfg_cont,
  input  logic [1:0]       cfg_unit,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             start_set,
  input  logic             done_clr,
  input  logic             xfer_req,
  output logic             snoop_req,
  output logic             gen_req,
  input  logic             snoop_gnt,
  input  logic             gen_gnt,
  input  logic             core_rel_req,
  output logic             cyc_act,
  output logic [2:0]       cyc_bytes,
  input  logic             cyc_done,
  output logic             ack,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] byte_cnt
);

  logic [UNIT_W-1:0] unit_q, clip_nx;
  logic dec, pend_clr, pend, nx_zero, zero_hit;

  assign zero_hit = dec && nx_zero;

  dma_byte_ctr #(.CNT_W(CNT_W), .UNIT_W(UNIT_W)) u_ctr (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
    .dec(dec), .unit_b(unit_q), .cnt(byte_cnt), .clip_nx(clip_nx),
    .nx_zero(nx_zero)
  );

  dma_req_track u_trk (
    .clk(clk), .rst(rst), .xfer_req(xfer_req), .start_set(start_set),
    .cnt_nonzero(byte_cnt != '0), .pend_clr(pend_clr), .zero_hit(zero_hit),
    .done_clr(done_clr), .busy(busy), .done(done), .pend(pend)
  );

  dma_seq_fsm #(.UNIT_W(UNIT_W)) u_fsm (
    .clk(clk), .rst(rst), .cfg_snoop(cfg_snoop), .cfg_rel_en(cfg_rel_en),
    .cfg_cont(cfg_cont), .cfg_unit(cfg_unit), .busy(busy), .pend(pend),
    .snoop_gnt(snoop_gnt), .gen_gnt(gen_gnt), .core_rel_req(core_rel_req),
    .cyc_done(cyc_done), .nx_zero(nx_zero), .clip_nx(clip_nx),
    .unit_q(unit_q), .dec(dec), .pend_clr(pend_clr), .snoop_req(snoop_req),
    .gen_req(gen_req), .cyc_act(cyc_act), .cyc_bytes(cyc_bytes), .ack(ack)
  );

  // R9
  busy_needs_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(byte_cnt) != '0));

endmodule

// File: tb/dma_bus_seq_bench.sv
module dma_bus_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_snoop = 0, cfg_rel_en = 0, cfg_cont = 0;
  logic [1:0] cfg_unit = 2'b00;
  logic cnt_load = 0, start_set = 0, done_clr = 0, xfer_req = 0;
  logic [31:0] cnt_val = '0;
  logic core_rel_req = 0;
  logic auto_gnt = 0, auto_done = 0;
  logic man_snoop_gnt = 0, man_gen_gnt = 0, man_done = 0;
  logic snoop_req, gen_req, snoop_gnt, gen_gnt, cyc_act, cyc_done, ack, busy, done;
  logic [2:0] cyc_bytes;
  logic [31:0] byte_cnt;
  int checks = 0, failures = 0;
  bit finished = 0;

  assign snoop_gnt = auto_gnt ? snoop_req : man_snoop_gnt;
  assign gen_gnt   = auto_gnt ? gen_req   : man_gen_gnt;
  assign cyc_done  = auto_done ? cyc_act  : man_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_bus_seq u_dma_bus_seq (
    .clk(clk), .rst(rst), .cfg_snoop(cfg_snoop), .cfg_rel_en(cfg_rel_en),
    .cfg_cont(cfg_cont), .cfg_unit(cfg_unit), .cnt_load(cnt_load),
    .cnt_val(cnt_val), .start_set(start_set), .done_clr(done_clr),
    .xfer_req(xfer_req), .snoop_req(snoop_req), .gen_req(gen_req),
    .snoop_gnt(snoop_gnt), .gen_gnt(gen_gnt), .core_rel_req(core_rel_req),
    .cyc_act(cyc_act), .cyc_bytes(cyc_bytes), .cyc_done(cyc_done),
    .ack(ack), .busy(busy), .done(done), .byte_cnt(byte_cnt)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setup(input bit snp, input bit rel, input bit cont,
                       input logic [1:0] unit, input logic [31:0] n);
    cfg_snoop = snp; cfg_rel_en = rel; cfg_cont = cont; cfg_unit = unit;
    cnt_val = n; cnt_load = 1; tick(); cnt_load = 0;
    start_set = 1; tick(); start_set = 0;
  endtask

  task automatic wait_ack(input string req);
    int n = 0;
    while (!ack && n < 40) begin tick(); n++; end
    chk(ack, req, "ack seen", ack, 1);
  endtask

  task automatic t_reset();
    chk(!snoop_req && !gen_req && !cyc_act && !ack && !busy && !done, "R10",
        "outputs low", {snoop_req, gen_req, cyc_act, ack, busy, done}, 0);
    chk(byte_cnt == 0, "R10", "byte_cnt", byte_cnt, 0);
    cnt_val = 0; cnt_load = 1; tick(); cnt_load = 0;
    start_set = 1; tick(); start_set = 0; tick();
    chk(!busy, "R9", "start with zero count", busy, 0);
  endtask

  task automatic t_single_snoop();
    int n = 0;
    setup(1, 0, 0, 2'b01, 6);
    xfer_req = 1;
    while (!snoop_req && n < 10) begin tick(); n++; end
    chk(snoop_req, "R1", "snoop_req raised", snoop_req, 1);
    chk(!gen_req, "R1", "gen_req low in snoop mode", gen_req, 0);
    man_gen_gnt = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(!cyc_act, "R2", "no cycle on wrong grant", cyc_act, 0);
    end
    man_gen_gnt = 0; man_snoop_gnt = 1; tick(); man_snoop_gnt = 0;
    chk(cyc_act, "R2", "cycle after grant", cyc_act, 1);
    chk(cyc_bytes == 2, "R5", "unit 2 bytes", cyc_bytes, 2);
    man_done = 1; tick(); man_done = 0;
    chk(ack, "R3", "ack after unit", ack, 1);
    chk(byte_cnt == 4, "R5", "count after unit", byte_cnt, 4);
    tick();
    chk(!ack, "R3", "ack one cycle", ack, 0);
    chk(!snoop_req, "R6", "request dropped after ack", snoop_req, 0);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(!snoop_req && !cyc_act, "R3", "held request ignored", snoop_req, 0);
    end
    xfer_req = 0; auto_gnt = 1; auto_done = 1; tick();
    xfer_req = 1; tick();
    wait_ack("R3");
    chk(byte_cnt == 2, "R3", "second unit count", byte_cnt, 2);
    xfer_req = 0; tick(); xfer_req = 1; tick();
    wait_ack("R3");
    chk(byte_cnt == 0, "R5", "final count", byte_cnt, 0);
    chk(done && !busy, "R9", "done set busy clear", {done, busy}, 2);
    xfer_req = 0;
    for (int i = 0; i < 3; i++) tick();
    chk(done, "R9", "done sticky", done, 1);
    done_clr = 1; tick(); done_clr = 0;
    chk(!done, "R9", "done cleared", done, 0);
    auto_gnt = 0; auto_done = 0;
  endtask

  task automatic t_cont_clip();
    int acks = 0, units = 0, fell = 0;
    logic prev = 0;
    logic [2:0] sz [2];
    setup(0, 0, 1, 2'b10, 7);
    auto_gnt = 1; auto_done = 1;
    xfer_req = 1; tick(); xfer_req = 0;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (!snoop_req && gen_req === 1'b0 && prev && acks == 0) fell++;
      if (cyc_act && cyc_done) begin
        if (units < 2) sz[units] = cyc_bytes;
        units++;
      end
      if (ack) begin
        acks++;
        chk(byte_cnt == 0, "R4", "ack only at zero", byte_cnt, 0);
      end
      if (gen_req) chk(!snoop_req, "R1", "single line", snoop_req, 0);
      prev = gen_req;
    end
    chk(units == 2, "R4", "unit count", units, 2);
    chk(sz[0] == 4, "R5", "first unit 4", sz[0], 4);
    chk(sz[1] == 3, "R5", "clipped unit", sz[1], 3);
    chk(acks == 1, "R4", "one ack", acks, 1);
    chk(fell == 0, "R4", "no request drop before ack", fell, 0);
    chk(done, "R9", "done after continuous", done, 1);
    done_clr = 1; tick(); done_clr = 0;
    auto_gnt = 0; auto_done = 0;
  endtask

  task automatic t_release_gen();
    int n = 0;
    setup(0, 1, 1, 2'b00, 3);
    auto_gnt = 1;
    xfer_req = 1; tick(); xfer_req = 0;
    while (!cyc_act && n < 10) begin tick(); n++; end
    core_rel_req = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(cyc_act && gen_req, "R7", "no mid-cycle release", cyc_act, 1);
    end
    man_done = 1; tick(); man_done = 0;
    chk(!gen_req && !cyc_act, "R7", "released at boundary", gen_req, 0);
    chk(byte_cnt == 2, "R7", "count at release", byte_cnt, 2);
    core_rel_req = 0;
    n = 0;
    while (!gen_req && n < 8) begin tick(); n++; end
    chk(gen_req, "R7", "request again", gen_req, 1);
    auto_done = 1;
    wait_ack("R7");
    chk(byte_cnt == 0, "R7", "finished after re-request", byte_cnt, 0);
    tick(); done_clr = 1; tick(); done_clr = 0;
    auto_gnt = 0; auto_done = 0;
  endtask

  task automatic t_release_ignored(input bit snp, input bit rel);
    int fell = 0, acks = 0;
    logic prev = 0;
    setup(snp, rel, 1, 2'b00, 4);
    auto_gnt = 1; auto_done = 1; core_rel_req = 1;
    xfer_req = 1; tick(); xfer_req = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (prev && !(snoop_req || gen_req) && acks == 0) fell++;
      if (ack) acks++;
      prev = snoop_req || gen_req;
    end
    chk(fell == 0, "R8", "no release", fell, 0);
    chk(acks == 1 && byte_cnt == 0, "R8", "run completed", acks, 1);
    core_rel_req = 0; done_clr = 1; tick(); done_clr = 0;
    auto_gnt = 0; auto_done = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    t_reset();
    t_single_snoop();
    t_cont_clip();
    t_release_gen();
    t_release_ignored(1, 1);
    t_release_ignored(0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule